// File: doc/BRIEF.md
# Overlay Slot Allocator

This block hands out hardware overlay slots from a pool of eight inside one display group. A client sends one request at a time. The request gives a plane count of one or two, a source type (memory, live input A or live input B), the group index, the index of the target output and that group's output-split mask. The block keeps a free-slot bitmask. It answers one cycle after acceptance with a slot index or with a busy or invalid error. On success it removes the granted slots from the pool.

Memory-sourced requests search from the highest slot down. A two-plane request needs a slot together with its wrap-around neighbour. Live sources are pinned to a fixed slot. Every request first tries the slots preferred by the target output. If that fails, it falls back to the whole free pool. A separate release port hands slots back to the pool.

The control is a two-state machine. In IDLE the block is ready and accepts a request (IDLE to RESP on `req_valid`). In RESP it presents the result for exactly one cycle and then returns unconditionally (RESP to IDLE).

Top module: `ovl_slot_alloc`

## Requirements
- R1: After reset, `free_mask` is 8'hFF (1 = free), `resp_valid` is 0 and `req_ready` is 1.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `resp_valid` is 1 during exactly the next cycle, and `req_ready` is 0 during that cycle.
- R3: A memory request (`req_src` = 0) for one plane is granted the highest-numbered free slot in the searched mask.
- R4: A memory request for two planes (`req_two` = 1) is granted the highest slot i for which both slot i and slot (i+1) mod 8 are free. Slot 7 pairs with slot 0.
- R5: A live-A request (`req_src` = 1) is pinned to slot 0. It is legal only when `req_group` is 0; in any other group it returns `resp_invalid` = 1. If slot 0 is not free it returns `resp_busy` = 1.
- R6: A live-B request (`req_src` = 2) is pinned to slot 1 when `req_group` is 0 and to slot 0 otherwise. If the pinned slot is not free it returns `resp_busy` = 1.
- R7: The first attempt searches `free_mask & pref`, where pref is `split_mask` when `req_out_idx` is odd and `~split_mask` when it is even. If the first attempt finds nothing, the block searches the full `free_mask` before it reports busy.
- R8: On success, the granted slot is cleared from `free_mask`, together with its partner for a two-plane memory grant; live grants take one slot only. On busy or invalid, the mask is unchanged and `resp_slot` is 0.
- R9: A release (`rel_valid`) sets slot `rel_slot`, and slot (`rel_slot`+1) mod 8 as well when `rel_two` = 1, back to free at the next edge. When a grant and a release touch the same bit at the same edge, the grant wins.
- R10: Source code 3 is reserved; such a request returns `resp_invalid` = 1 and leaves the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_two | input | 1 | 1 = two-plane request |
| req_src | input | 2 | 0 memory, 1 live A, 2 live B, 3 reserved |
| req_group | input | 2 | Display group index |
| req_out_idx | input | 3 | Target output index (parity selects preference) |
| split_mask | input | 8 | Output-split slot mask of the group |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_slot | output | 3 | Granted slot index |
| resp_busy | output | 1 | No suitable slot was free |
| resp_invalid | output | 1 | Request illegal for this group or source |
| rel_valid | input | 1 | Release strobe |
| rel_slot | input | 3 | First slot to release |
| rel_two | input | 1 | Release the wrap-around partner as well |
| free_mask | output | 8 | Current free-slot mask |

## Verification
The bench fills the pool one slot at a time, which shows the downward search order. It then frees only slots 7 and 0, so a pair request can succeed only through the wrap-around pairing. Pinned requests are tried in group 0 and in another group, with the pinned slot both taken and free; this separates the invalid, busy and granted outcomes from each other. Preference masks are chosen so that the first attempt and the fallback would give different slots. One grant and one release hit the same bit in the same cycle. Random requests and releases, checked against a bench model, then cover mixed pool states.

// File: rtl/ovl_alloc_pkg.sv
package ovl_alloc_pkg;
    typedef enum logic [1:0] {
        SRC_MEM    = 2'd0,
        SRC_LIVE_A = 2'd1,
        SRC_LIVE_B = 2'd2,
        SRC_RSVD   = 2'd3
    } src_e;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } alloc_st_e;
endpackage

// File: rtl/ovl_slot_span.sv
// Expands a slot index and plane count into a slot bitmask (wraps at N).
module ovl_slot_span #(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic [SW-1:0]      slot,
    input  logic               two,
    output logic [N_SLOTS-1:0] bits
);
    logic [SW-1:0] partner;

    assign partner = (slot == SW'(N_SLOTS - 1)) ? '0 : slot + 1'b1;

    always_comb begin
        for (int i = 0; i < N_SLOTS; i++) begin
            bits[i] = (slot == SW'(i)) || (two && (partner == SW'(i)));
        end
    end
endmodule

// File: rtl/ovl_slot_search.sv
// One allocation attempt over a candidate mask.
module ovl_slot_search
    import ovl_alloc_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int GROUP_W = 2,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] avail,
    input  logic               two,
    input  src_e               src,
    input  logic [GROUP_W-1:0] group,
    output logic               found,
    output logic               illegal,
    output logic [SW-1:0]      slot
);
    logic          pinned;
    logic [SW-1:0] pin_idx;
    logic          scan_ok;
    logic [SW-1:0] scan_idx;

    always_comb begin
        pinned  = 1'b0;
        pin_idx = '0;
        illegal = 1'b0;
        unique case (src)
            SRC_MEM:    pinned = 1'b0;
            SRC_LIVE_A: begin
                pinned  = 1'b1;
                illegal = (group != '0);
            end
            SRC_LIVE_B: begin
                pinned  = 1'b1;
                pin_idx = (group == '0) ? SW'(1) : '0;
            end
            SRC_RSVD:   illegal = 1'b1;
        endcase
    end

    // Ascending scan; the last hit is the highest qualifying slot.
    always_comb begin
        scan_ok  = 1'b0;
        scan_idx = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (avail[i] && (!two || avail[(i + 1) % N_SLOTS])) begin
                scan_ok  = 1'b1;
                scan_idx = SW'(i);
            end
        end
    end

    always_comb begin
        if (illegal) begin
            found = 1'b0;
            slot  = '0;
        end else if (pinned) begin
            found = avail[pin_idx];
            slot  = pin_idx;
        end else begin
            found = scan_ok;
            slot  = scan_idx;
        end
    end
endmodule

// File: rtl/ovl_slot_alloc.sv
module ovl_slot_alloc
    import ovl_alloc_pkg::*;
#(
    parameter int N_SLOTS = 8,
    parameter int GROUP_W = 2,
    parameter int OUT_W   = 3,
    localparam int SW = $clog2(N_SLOTS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_two,
    input  logic [1:0]         req_src,
    input  logic [GROUP_W-1:0] req_group,
    input  logic [OUT_W-1:0]   req_out_idx,
    input  logic [N_SLOTS-1:0] split_mask,
    output logic               resp_valid,
    output logic [SW-1:0]      resp_slot,
    output logic               resp_busy,
    output logic               resp_invalid,
    input  logic               rel_valid,
    input  logic [SW-1:0]      rel_slot,
    input  logic               rel_two,
    output logic [N_SLOTS-1:0] free_mask
);
    localparam int N_TRY = 2;  // 0: preferred, 1: full pool

    alloc_st_e state, state_nx;
    src_e      src;

    logic [N_SLOTS-1:0] try_mask [N_TRY];
    logic [N_TRY-1:0]   try_found;
    logic [N_TRY-1:0]   try_illegal;
    logic [SW-1:0]      try_slot [N_TRY];

    logic               accept;
    logic               grant_ok;
    logic               grant_bad;
    logic [SW-1:0]      grant_slot;
    logic               grant_two;
    logic [N_SLOTS-1:0] grant_bits;
    logic [N_SLOTS-1:0] rel_bits;
    logic [N_SLOTS-1:0] pref_mask;

    assign src       = src_e'(req_src);
    assign pref_mask = req_out_idx[0] ? split_mask : ~split_mask;
    assign try_mask[0] = free_mask & pref_mask;
    assign try_mask[1] = free_mask;

    for (genvar k = 0; k < N_TRY; k++) begin : g_try
        ovl_slot_search #(.N_SLOTS(N_SLOTS), .GROUP_W(GROUP_W)) u_search (
            .avail   (try_mask[k]),
            .two     (req_two),
            .src     (src),
            .group   (req_group),
            .found   (try_found[k]),
            .illegal (try_illegal[k]),
            .slot    (try_slot[k])
        );
    end

    always_comb begin
        grant_bad  = try_illegal[0];
        grant_ok   = 1'b0;
        grant_slot = '0;
        if (!grant_bad) begin
            if (try_found[0]) begin
                grant_ok   = 1'b1;
                grant_slot = try_slot[0];
            end else if (try_found[1]) begin
                grant_ok   = 1'b1;
                grant_slot = try_slot[1];
            end
        end
    end

    assign grant_two = req_two && (src == SRC_MEM);

    ovl_slot_span #(.N_SLOTS(N_SLOTS)) u_grant_span (
        .slot (grant_slot),
        .two  (grant_two),
        .bits (grant_bits)
    );

    ovl_slot_span #(.N_SLOTS(N_SLOTS)) u_rel_span (
        .slot (rel_slot),
        .two  (rel_two),
        .bits (rel_bits)
    );

    assign accept = req_valid && req_ready;

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_RESP;
            ST_RESP: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Outputs from state.
    always_comb begin
        req_ready  = 1'b0;
        resp_valid = 1'b0;
        unique case (state)
            ST_IDLE: req_ready  = 1'b1;
            ST_RESP: resp_valid = 1'b1;
        endcase
    end

    // Result capture and pool update; grant clears after release sets.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            free_mask    <= '1;
            resp_slot    <= '0;
            resp_busy    <= 1'b0;
            resp_invalid <= 1'b0;
        end else begin
            free_mask <= (free_mask | (rel_valid ? rel_bits : '0))
                       & ~((accept && grant_ok) ? grant_bits : '0);
            if (accept) begin
                resp_slot    <= grant_slot;
                resp_busy    <= !grant_ok && !grant_bad;
                resp_invalid <= grant_bad;
            end
        end
    end
endmodule

// File: rtl/ovl_slot_alloc_chk.sv
module ovl_slot_alloc_chk #(
    parameter int N_SLOTS = 8,
    localparam int SW = $clog2(N_SLOTS)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic [SW-1:0]      resp_slot,
    input logic               resp_busy,
    input logic               resp_invalid,
    input logic               rel_valid,
    input logic [N_SLOTS-1:0] free_mask
);
    logic resp_ok;
    assign resp_ok = resp_valid && !resp_busy && !resp_invalid;

    p_resp_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> resp_valid);

    p_no_ready_in_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_single_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    p_flags_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_busy && resp_invalid));

    p_grant_was_free_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> ((($past(free_mask) >> resp_slot) & 1) != 0));

    p_grant_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_ok |-> (((free_mask >> resp_slot) & 1) == 0));

    p_fail_keeps_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ok && !$past(rel_valid)) |-> free_mask == $past(free_mask));

    p_rise_needs_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rel_valid) |-> (free_mask & ~$past(free_mask)) == '0);
endmodule

bind ovl_slot_alloc ovl_slot_alloc_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .resp_valid   (resp_valid),
    .resp_slot    (resp_slot),
    .resp_busy    (resp_busy),
    .resp_invalid (resp_invalid),
    .rel_valid    (rel_valid),
    .free_mask    (free_mask)
);

// File: tb/tb_ovl_slot_alloc.sv
`timescale 1ns/1ps
module tb_ovl_slot_alloc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_two = 1'b0;
    logic [1:0] req_src = 2'd0;
    logic [1:0] req_group = 2'd0;
    logic [2:0] req_out_idx = 3'd0;
    logic [7:0] split_mask = 8'h00;
    logic       resp_valid;
    logic [2:0] resp_slot;
    logic       resp_busy;
    logic       resp_invalid;
    logic       rel_valid = 1'b0;
    logic [2:0] rel_slot = 3'd0;
    logic       rel_two = 1'b0;
    logic [7:0] free_mask;

    int vectors = 0;
    int miscompares = 0;
    logic [7:0] mfree;
    bit done = 0;

    always #10 clk = ~clk;

    ovl_slot_alloc dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_two(req_two), .req_src(req_src), .req_group(req_group),
        .req_out_idx(req_out_idx), .split_mask(split_mask),
        .resp_valid(resp_valid), .resp_slot(resp_slot), .resp_busy(resp_busy),
        .resp_invalid(resp_invalid), .rel_valid(rel_valid), .rel_slot(rel_slot),
        .rel_two(rel_two), .free_mask(free_mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] span(input logic [2:0] s, input logic two);
        logic [7:0] m;
        m = 8'h01 << s;
        if (two) m = m | (8'h01 << ((s + 3'd1) & 3'd7));
        return m;
    endfunction

    // returns {ok, slot[2:0], bits[7:0]}
    function automatic logic [11:0] pick(input logic [7:0] m, input logic two,
                                         input logic [1:0] src, input logic [1:0] grp);
        logic [2:0] p;
        if (src != 2'd0) begin
            p = (src == 2'd1) ? 3'd0 : ((grp == 2'd0) ? 3'd1 : 3'd0);
            return {m[p], p, span(p, 1'b0)};
        end
        for (int i = 7; i >= 0; i--) begin
            if (m[i] && (!two || m[(i + 1) % 8])) return {1'b1, 3'(i), span(3'(i), two)};
        end
        return 12'd0;
    endfunction

    // returns {busy, invalid, slot[2:0], bits[7:0]}
    function automatic logic [12:0] model(input logic [7:0] fr, input logic two,
            input logic [1:0] src, input logic [1:0] grp, input logic [2:0] outi,
            input logic [7:0] split);
        logic [7:0]  pref;
        logic [11:0] r;
        pref = outi[0] ? split : ~split;
        if (src == 2'd3 || (src == 2'd1 && grp != 2'd0)) return {1'b0, 1'b1, 3'd0, 8'd0};
        r = pick(fr & pref, two, src, grp);
        if (!r[11]) r = pick(fr, two, src, grp);
        if (!r[11]) return {1'b1, 1'b0, 3'd0, 8'd0};
        return {2'b00, r[10:0]};
    endfunction

    task automatic do_req(input string tag, input logic two, input logic [1:0] src,
                          input logic [1:0] grp, input logic [2:0] outi, input logic [7:0] split,
                          input logic rv, input logic [2:0] rs, input logic rt);
        logic [12:0] e;
        @(negedge clk);
        chk({tag, " R2 ready idle"}, req_ready, 1'b1);
        chk({tag, " R2 no stale resp"}, resp_valid, 1'b0);
        e = model(mfree, two, src, grp, outi, split);
        req_valid = 1'b1; req_two = two; req_src = src; req_group = grp;
        req_out_idx = outi; split_mask = split;
        rel_valid = rv; rel_slot = rs; rel_two = rt;
        @(negedge clk);
        req_valid = 1'b0; rel_valid = 1'b0;
        mfree = (mfree | (rv ? span(rs, rt) : 8'h00)) & ~e[7:0];
        chk({tag, " R2 resp_valid"}, resp_valid, 1'b1);
        chk({tag, " R2 ready low"}, req_ready, 1'b0);
        chk({tag, " R8 busy"}, resp_busy, e[12]);
        chk({tag, " R5 R10 invalid"}, resp_invalid, e[11]);
        chk({tag, " R3 R4 slot"}, resp_slot, e[10:8]);
        chk({tag, " R8 R9 mask"}, free_mask, mfree);
    endtask

    task automatic do_rel(input string tag, input logic [2:0] s, input logic two);
        @(negedge clk);
        rel_valid = 1'b1; rel_slot = s; rel_two = two;
        @(negedge clk);
        rel_valid = 1'b0;
        mfree = mfree | span(s, two);
        chk({tag, " R9 release"}, free_mask, mfree);
    endtask

    initial begin
        #3000000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [31:0] r;
        mfree = 8'hFF;
        seed = 32'd1234;
        r = $urandom(seed);
        repeat (3) @(negedge clk);
        chk("R1 free_mask", free_mask, 8'hFF);
        chk("R1 resp_valid", resp_valid, 1'b0);
        chk("R1 req_ready", req_ready, 1'b1);
        rst_n = 1'b1;

        // R3: fill downward, then busy on a full pool
        for (int i = 0; i < 8; i++) do_req("R3 fill", 0, 0, 0, 0, 8'h00, 0, 0, 0);
        do_req("R8 full busy", 0, 0, 0, 0, 8'h00, 0, 0, 0);
        // R4: only 7 and 0 free -> wrap pair at 7
        do_rel("R9 a", 3'd7, 0);
        do_rel("R9 b", 3'd0, 0);
        do_req("R4 wrap pair", 1, 0, 0, 0, 8'h00, 0, 0, 0);
        do_rel("R9 pair", 3'd3, 1);
        do_req("R4 mid pair", 1, 0, 0, 0, 8'h00, 0, 0, 0);
        // R5: live A
        do_req("R5 group1", 0, 1, 1, 0, 8'h00, 0, 0, 0);
        do_req("R5 busy", 0, 1, 0, 0, 8'h00, 0, 0, 0);
        do_rel("R9 c", 3'd0, 0);
        do_req("R5 grant", 1, 1, 0, 0, 8'h00, 0, 0, 0);
        // R6: live B
        do_req("R6 busy", 0, 2, 0, 0, 8'h00, 0, 0, 0);
        do_rel("R9 d", 3'd1, 0);
        do_req("R6 grant g0", 0, 2, 0, 0, 8'h00, 0, 0, 0);
        do_req("R6 busy g2", 0, 2, 2, 0, 8'h00, 0, 0, 0);
        do_rel("R9 e", 3'd0, 0);
        do_req("R6 grant g2", 0, 2, 2, 0, 8'h00, 0, 0, 0);
        // R10 reserved source
        do_req("R10 rsvd", 0, 3, 0, 0, 8'h00, 0, 0, 0);
        // R7 preference and fallback
        for (int i = 0; i < 8; i += 2) do_rel("R9 all", 3'(i), 1);
        do_req("R7 odd pref", 0, 0, 0, 3'd1, 8'h0F, 0, 0, 0);
        do_req("R7 even pref", 0, 0, 0, 3'd2, 8'h0F, 0, 0, 0);
        do_req("R7 fallback", 0, 0, 0, 3'd1, 8'h00, 0, 0, 0);
        // R9 grant beats same-bit release
        do_req("R9 conflict", 0, 0, 0, 0, 8'h00, 1, 3'd5, 0);

        for (int n = 0; n < 600; n++) begin
            r = $urandom;
            if (r[2:0] < 3'd3) do_rel("R9 rnd", r[5:3], r[6]);
            else do_req("R7 rnd", r[7], (r[10:8] < 3'd5) ? 2'd0 : r[12:11],
                        r[14:13], r[17:15], r[25:18], r[26], r[29:27], r[30]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule